// File: doc/BRIEF.md
# Serial GPIO Bitstream Controller

This block drives a chain of external shift registers that extend a chip's general purpose pins. Up to 32 ports sit on the chain, and each carries one to four bits. During a burst the controller shifts the static output level of every bit of every enabled port out on a serial data line. At the same time it samples a serial data line coming back from the chain. A load strobe at the end of the burst makes the external registers latch their outputs. The sampled bits are committed at once into one input word per bit index, so software always reads a coherent snapshot.

Software sets up the block through a plain single-cycle register port. The settings are the per-port bit count, a port-enable mask, one output word per port, the serial clock divisor and the gap between bursts. Bursts either repeat on their own, or run exactly once each time a self-clearing single-shot bit is set while auto-repeat is off. The serial pins have no handshake: the external chain accepts every bit, so no back-pressure exists anywhere in the block.

Register map (word addresses). Address 0 is control:
- bit 0: interrupt enable
- bits 2:1: bits per port minus one
- bit 3: auto-repeat
- bit 4: single-shot

The other registers:
- 1: divisor (12 bits)
- 2: gap (8 bits)
- 3: port-enable mask
- 4 to 7: read-only input words for bit 0 to bit 3
- 32 + p: output word of port p (12 bits)

Top module: `serial_gpio_ctrl`

## Requirements
- R1: While a burst runs, the serial clock period is max(2, divisor) system clocks; divisor values 0 and 1 act as 2.
- R2: A burst sends ports in ascending order and, inside each port, bit 0 first, for (control bits 2:1)+1 bits per port. Ports whose mask bit is 0 are skipped entirely. Data changes on the serial clock fall and is stable at its rise.
- R3: The level sent for bit n of port p is bit 3n of that port's output word. The other bits of the word are stored and read back unchanged but do not affect the serial output.
- R4: Serial input is sampled on serial clock rises. After the burst, bit p of input word b holds the sample for port p, bit b. Bits of disabled ports and bit indices beyond the port width read 0.
- R5: After the last bit, the load strobe rises together with a serial clock fall and stays high for exactly one serial clock period. The input snapshot is committed as it falls.
- R6: Setting single-shot while auto-repeat is off starts one burst, and hardware clears the bit (control bit 4 reads 0) once that burst has committed.
- R7: With auto-repeat on, bursts repeat with (gap+1)·period system clocks from the load strobe fall to the next serial clock fall, and single-shot is never cleared by hardware.
- R8: The interrupt output pulses for exactly one system clock on each snapshot commit when control bit 0 is set, and stays low otherwise.
- R9: After reset the serial clock is high, data, load and interrupt are low, control, gap, mask and input words read 0, and the divisor reads 2.
- R10: Once auto-repeat and single-shot are both cleared, bursts stop after the current one and the serial clock stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| sclk_o | output | 1 | Serial clock, idles high |
| sdo_o | output | 1 | Serial data to the chain |
| sload_o | output | 1 | Load strobe to the chain |
| sdi_i | input | 1 | Serial data from the chain |
| irq_o | output | 1 | Snapshot-committed interrupt pulse |

## Verification
A register write takes effect at the next clock edge, and reads are combinational. A burst therefore begins at the first divider fall after the write, between one and one period later, so the bench waits on the block's own edges and does not count cycles to the start. Output bits are captured on each serial clock rise with the load strobe low, and chain input is driven on each fall. Input words, the interrupt count and the single-shot bit are checked three system clocks after the load strobe falls, when the commit and the single-shot clear have both had time to register. Periods, the strobe width and the gap are measured as time differences between the recorded edges and divided by the 5 ns clock.

// File: rtl/sgc_pkg.sv
package sgc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_LOAD, ST_GAP} seq_st_t;
  localparam int CFG_IRQ  = 0;
  localparam int CFG_AUTO = 3;
  localparam int CFG_SS   = 4;
  localparam int A_CFG    = 0;
  localparam int A_DIV    = 1;
  localparam int A_GAP    = 2;
  localparam int A_PEN    = 3;
endpackage

// File: rtl/sgc_clkdiv.sv
module sgc_clkdiv #(
  parameter int DIVW = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DIVW-1:0] div_i,
  output logic            fall_o,
  output logic            rise_o
);
  logic [DIVW-1:0] cnt, dmax, half;

  always_comb begin
    dmax = (div_i < DIVW'(2)) ? DIVW'(2) : div_i;
    half = dmax >> 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt <= '0;
    else if (cnt >= dmax - DIVW'(1)) cnt <= '0;
    else                            cnt <= cnt + DIVW'(1);
  end

  assign fall_o = (cnt == '0);
  assign rise_o = (cnt == half);

  // R1: the divisor clamp keeps the two serial clock events apart
  a_r1_events_apart: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fall_o, rise_o}));
  a_r1_no_back_to_back_fall: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);
endmodule

// File: rtl/sgc_regs.sv
module sgc_regs import sgc_pkg::*; #(
  parameter int NPORT = 32,
  parameter int MAXB  = 4,
  parameter int DIVW  = 12,
  parameter int GAPW  = 8,
  localparam int PW   = $clog2(NPORT),
  localparam int BW   = $clog2(MAXB),
  localparam int FW   = 3 * MAXB,
  localparam int AW   = PW + 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_i,
  input  logic [AW-1:0]               addr_i,
  input  logic [31:0]                 wdata_i,
  output logic [31:0]                 rdata_o,
  input  logic                        ss_clr_i,
  input  logic [MAXB-1:0][NPORT-1:0]  in_words_i,
  output logic                        irq_en_o,
  output logic [BW-1:0]               wsel_o,
  output logic                        auto_o,
  output logic                        ss_o,
  output logic [DIVW-1:0]             div_o,
  output logic [GAPW-1:0]             gap_o,
  output logic [NPORT-1:0]            pen_o,
  output logic [NPORT-1:0][MAXB-1:0]  lvl_o
);
  logic [FW-1:0] pcfg [NPORT];
  logic low_hit, wr_cfg;

  assign low_hit = !addr_i[AW-1] && (addr_i[AW-2:3] == '0);
  assign wr_cfg  = wr_i && low_hit && (addr_i[2:0] == 3'(A_CFG));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en_o <= 1'b0;
      wsel_o   <= '0;
      auto_o   <= 1'b0;
      ss_o     <= 1'b0;
      div_o    <= DIVW'(2);
      gap_o    <= '0;
      pen_o    <= '0;
      for (int i = 0; i < NPORT; i++) pcfg[i] <= '0;
    end else begin
      if (wr_cfg) begin
        irq_en_o <= wdata_i[CFG_IRQ];
        wsel_o   <= wdata_i[BW:1];
        auto_o   <= wdata_i[CFG_AUTO];
        ss_o     <= wdata_i[CFG_SS];
      end else if (ss_clr_i) begin
        ss_o <= 1'b0;
      end
      if (wr_i && low_hit && addr_i[2:0] == 3'(A_DIV)) div_o <= wdata_i[DIVW-1:0];
      if (wr_i && low_hit && addr_i[2:0] == 3'(A_GAP)) gap_o <= wdata_i[GAPW-1:0];
      if (wr_i && low_hit && addr_i[2:0] == 3'(A_PEN)) pen_o <= wdata_i[NPORT-1:0];
      if (wr_i && addr_i[AW-1]) pcfg[addr_i[PW-1:0]] <= wdata_i[FW-1:0];
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    for (genvar b = 0; b < MAXB; b++) begin : g_bit
      assign lvl_o[p][b] = pcfg[p][3*b];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i[AW-1]) begin
      rdata_o[FW-1:0] = pcfg[addr_i[PW-1:0]];
    end else if (low_hit) begin
      case (addr_i[2:0])
        3'(A_CFG): rdata_o[CFG_SS:0] = {ss_o, auto_o, wsel_o, irq_en_o};
        3'(A_DIV): rdata_o[DIVW-1:0] = div_o;
        3'(A_GAP): rdata_o[GAPW-1:0] = gap_o;
        3'(A_PEN): rdata_o[NPORT-1:0] = pen_o;
        default:   if (int'(addr_i[1:0]) < MAXB) rdata_o[NPORT-1:0] = in_words_i[addr_i[1:0]];
      endcase
    end
  end

  // R7: single-shot survives while auto-repeat is on and software leaves it alone
  a_r7_ss_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_o && ss_o && !wr_cfg) |=> ss_o);
  // R6: single-shot only drops through a hardware clear or a software write
  a_r6_ss_clear_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ss_o) |-> $past(ss_clr_i || wr_cfg));
endmodule

// File: rtl/sgc_seq.sv
module sgc_seq import sgc_pkg::*; #(
  parameter int NPORT = 32,
  parameter int MAXB  = 4,
  parameter int GAPW  = 8,
  localparam int PW   = $clog2(NPORT),
  localparam int BW   = $clog2(MAXB)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        fall_i,
  input  logic                        rise_i,
  input  logic                        auto_i,
  input  logic                        ss_i,
  input  logic [BW-1:0]               wsel_i,
  input  logic [GAPW-1:0]             gap_i,
  input  logic [NPORT-1:0]            pen_i,
  input  logic [NPORT-1:0][MAXB-1:0]  lvl_i,
  input  logic                        sdi_i,
  output logic                        sclk_o,
  output logic                        sdo_o,
  output logic                        sload_o,
  output logic                        done_o,
  output logic                        ss_clr_o,
  output logic [MAXB-1:0][NPORT-1:0]  in_words_o
);
  seq_st_t st;
  logic [PW-1:0] cur_p, first_p, nxt_p, adv_p;
  logic [BW-1:0] cur_b, adv_b;
  logic [GAPW-1:0] gcnt;
  logic [MAXB-1:0][NPORT-1:0] shadow;
  logic first_v, nxt_v, port_end, last, start_req, go;

  always_comb begin
    first_v = 1'b0; first_p = '0;
    nxt_v   = 1'b0; nxt_p   = '0;
    for (int i = NPORT - 1; i >= 0; i--) begin
      if (pen_i[i]) begin
        first_v = 1'b1; first_p = PW'(i);
      end
      if (pen_i[i] && i > int'(cur_p)) begin
        nxt_v = 1'b1; nxt_p = PW'(i);
      end
    end
  end

  assign port_end  = (cur_b == wsel_i);
  assign last      = port_end && !nxt_v;
  assign adv_p     = port_end ? nxt_p : cur_p;
  assign adv_b     = port_end ? '0 : cur_b + BW'(1);
  assign start_req = auto_i || ss_i;
  assign go = fall_i && start_req &&
              (st == ST_IDLE || (st == ST_GAP && gcnt == '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; sclk_o <= 1'b1; sdo_o <= 1'b0; sload_o <= 1'b0;
      done_o <= 1'b0; ss_clr_o <= 1'b0; shadow <= '0; in_words_o <= '0;
      cur_p <= '0; cur_b <= '0; gcnt <= '0;
    end else begin
      done_o   <= 1'b0;
      ss_clr_o <= 1'b0;
      if (rise_i) begin
        sclk_o <= 1'b1;
        if (st == ST_SHIFT) shadow[cur_b][cur_p] <= sdi_i;
      end
      if (go) begin
        shadow <= '0;
        sclk_o <= 1'b0;
        if (first_v) begin
          st <= ST_SHIFT; cur_p <= first_p; cur_b <= '0;
          sdo_o <= lvl_i[first_p][0];
        end else begin
          st <= ST_LOAD; sload_o <= 1'b1;
        end
      end else if (fall_i) begin
        case (st)
          ST_SHIFT: begin
            sclk_o <= 1'b0;
            if (last) begin
              st <= ST_LOAD; sload_o <= 1'b1;
            end else begin
              cur_p <= adv_p; cur_b <= adv_b;
              sdo_o <= lvl_i[adv_p][adv_b];
            end
          end
          ST_LOAD: begin
            sload_o <= 1'b0;
            in_words_o <= shadow;
            done_o <= 1'b1;
            if (auto_i) begin
              st <= ST_GAP; gcnt <= gap_i;
            end else begin
              st <= ST_IDLE; ss_clr_o <= 1'b1;
            end
          end
          ST_GAP: begin
            if (gcnt != '0) gcnt <= gcnt - GAPW'(1);
            else            st <= ST_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  // R5: the load strobe opens on a serial clock fall
  a_r5_load_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sload_o) |-> !sclk_o);
  // R8: the commit pulse lasts one system clock
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R10: no serial clock activity outside a burst
  a_r10_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE || st == ST_GAP) |-> sclk_o);
endmodule

// File: rtl/serial_gpio_ctrl.sv
module serial_gpio_ctrl #(
  parameter int NPORT = 32,
  parameter int MAXB  = 4,
  parameter int DIVW  = 12,
  parameter int GAPW  = 8,
  localparam int AW   = $clog2(NPORT) + 1,
  localparam int BW   = $clog2(MAXB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          sclk_o,
  output logic          sdo_o,
  output logic          sload_o,
  input  logic          sdi_i,
  output logic          irq_o
);
  logic fall, rise, irq_en, auto_rep, ss, ss_clr, done;
  logic [BW-1:0] wsel;
  logic [DIVW-1:0] div;
  logic [GAPW-1:0] gap;
  logic [NPORT-1:0] pen;
  logic [NPORT-1:0][MAXB-1:0] lvl;
  logic [MAXB-1:0][NPORT-1:0] in_words;

  sgc_clkdiv #(.DIVW(DIVW)) u_div (
    .clk(clk), .rst_n(rst_n), .div_i(div), .fall_o(fall), .rise_o(rise));

  sgc_regs #(.NPORT(NPORT), .MAXB(MAXB), .DIVW(DIVW), .GAPW(GAPW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .rdata_o(reg_rdata), .ss_clr_i(ss_clr),
    .in_words_i(in_words), .irq_en_o(irq_en), .wsel_o(wsel),
    .auto_o(auto_rep), .ss_o(ss), .div_o(div), .gap_o(gap),
    .pen_o(pen), .lvl_o(lvl));

  sgc_seq #(.NPORT(NPORT), .MAXB(MAXB), .GAPW(GAPW)) u_seq (
    .clk(clk), .rst_n(rst_n), .fall_i(fall), .rise_i(rise),
    .auto_i(auto_rep), .ss_i(ss), .wsel_i(wsel), .gap_i(gap), .pen_i(pen),
    .lvl_i(lvl), .sdi_i(sdi_i), .sclk_o(sclk_o), .sdo_o(sdo_o),
    .sload_o(sload_o), .done_o(done), .ss_clr_o(ss_clr),
    .in_words_o(in_words));

  assign irq_o = done & irq_en;
endmodule

// File: tb/serial_gpio_ctrl_test.sv
`timescale 1ns/1ps
module serial_gpio_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic sclk_o, sdo_o, sload_o, irq_o;
  logic sdi_i = 1'b0;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  serial_gpio_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk_o(sclk_o),
    .sdo_o(sdo_o), .sload_o(sload_o), .sdi_i(sdi_i), .irq_o(irq_o));

  // external chain model
  logic [255:0] sdi_pat = '0, cap = '0;
  int ncap = 0, ndrv = 0, nfall = 0, nirq = 0;
  realtime t_prev = 0, t_last = 0, t_slr = 0, t_slf = 0;

  always @(posedge sclk_o) begin
    t_prev = t_last; t_last = $realtime;
    if (!sload_o) begin
      if (ncap < 256) cap[ncap] = sdo_o;
      ncap++;
    end
  end
  always @(negedge sclk_o) begin
    sdi_i = sdi_pat[ndrv % 256];
    ndrv++; nfall++;
  end
  always @(posedge sload_o) t_slr = $realtime;
  always @(negedge sload_o) t_slf = $realtime;
  always @(posedge clk) if (irq_o) nirq++;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input int a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = 6'(a); reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input int a, output logic [31:0] d);
    @(negedge clk); reg_addr = 6'(a); #1; d = reg_rdata;
  endtask

  function automatic logic [3:0] lv(input int p, input int s);
    return 4'((p * 7 + s * 3 + 5) ^ (p >> 2));
  endfunction

  function automatic logic [11:0] pword(input int p, input int s);
    logic [11:0] w = '0;
    logic [3:0] l = lv(p, s);
    for (int b = 0; b < 4; b++) begin
      w[3*b] = l[b]; w[3*b+1] = p[0]; w[3*b+2] = ~p[0];
    end
    return w;
  endfunction

  // one single-shot burst with full checking of R1..R6, R8
  task automatic run_burst(input logic [31:0] pen, input int wf, input int div,
                           input bit irq_en, input int s);
    logic [255:0] expb = '0;
    logic [3:0][31:0] expin = '0;
    logic [31:0] d;
    int k = 0, mism = 0, dd;
    dd = (div < 2) ? 2 : div;
    wr_reg(1, 32'(div));
    wr_reg(3, pen);
    for (int p = 0; p < 32; p++) wr_reg(32 + p, {20'b0, pword(p, s)});
    sdi_pat = {8{32'hA5C3_1E69 ^ 32'(s * 32'h01010101)}};
    ncap = 0; ndrv = 0; nirq = 0;
    wr_reg(0, 32'(irq_en) | 32'(wf << 1) | 32'h10);
    @(negedge sload_o);
    repeat (3) @(posedge clk);
    #1;
    for (int p = 0; p < 32; p++) begin
      if (pen[p]) begin
        for (int b = 0; b <= wf; b++) begin
          expb[k] = lv(p, s)[b];
          expin[b][p] = sdi_pat[k];
          k++;
        end
      end
    end
    check("R2 bit count", 64'(ncap), 64'(k));
    for (int i = 0; i < k; i++) if (cap[i] !== expb[i]) mism++;
    check("R2/R3 serial order and levels", 64'(mism), 64'd0);
    for (int b = 0; b < 4; b++) begin
      rd_reg(4 + b, d);
      check($sformatf("R4 input word %0d", b), 64'(d), 64'(expin[b]));
    end
    rd_reg(0, d);
    check("R6 single-shot self-clear", 64'(d[4]), 64'd0);
    check("R8 interrupt pulse count", 64'(nirq), 64'(irq_en));
    check("R1 serial clock period", 64'(int'((t_last - t_prev) / 5.0)), 64'(dd));
    check("R5 load strobe width", 64'(int'((t_slf - t_slr) / 5.0)), 64'(dd));
    rd_reg(32 + 5, d);
    check("R3 output word readback", 64'(d), 64'(pword(5, s)));
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R9 sclk idle high", 64'(sclk_o), 64'd1);
    check("R9 sdo low", 64'(sdo_o), 64'd0);
    check("R9 sload low", 64'(sload_o), 64'd0);
    check("R9 irq low", 64'(irq_o), 64'd0);
    rd_reg(0, d); check("R9 control reset", 64'(d), 64'd0);
    rd_reg(1, d); check("R9 divisor reset", 64'(d), 64'd2);
    rd_reg(3, d); check("R9 mask reset", 64'(d), 64'd0);
    rd_reg(6, d); check("R9 input word reset", 64'(d), 64'd0);
  endtask

  task automatic t_auto_repeat;
    logic [31:0] d;
    int f0;
    wr_reg(1, 32'd4);
    wr_reg(2, 32'd3);
    wr_reg(3, 32'h1);
    wr_reg(0, 32'h18);
    @(negedge sload_o);
    t_slf = $realtime;
    @(negedge sclk_o);
    check("R7 gap length", 64'(int'(($realtime - t_slf) / 5.0)), 64'd16);
    @(negedge sload_o);
    @(negedge sload_o);
    repeat (3) @(posedge clk);
    rd_reg(0, d);
    check("R7 single-shot held in auto-repeat", 64'(d[4]), 64'd1);
    wr_reg(0, 32'h0);
    repeat (300) @(posedge clk);
    f0 = nfall;
    repeat (200) @(posedge clk);
    #1;
    check("R10 bursts stopped", 64'(nfall - f0), 64'd0);
    check("R10 sclk idle high", 64'(sclk_o), 64'd1);
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    t_reset();
    run_burst(32'h0000_0001, 3, 5, 1'b1, 1);   // R1 odd divisor
    run_burst(32'h0000_0001, 3, 0, 1'b0, 2);   // R1 divisor clamped to 2
    run_burst(32'h8000_0021, 3, 3, 1'b1, 3);   // R2 sparse mask, four bits
    run_burst(32'h0000_0F0A, 1, 4, 1'b0, 4);   // R4 two bits, upper words zero
    run_burst(32'hFFFF_FFFF, 0, 2, 1'b1, 5);   // R2 every port, one bit
    t_auto_repeat();                           // R7, R10
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule